// File: doc/BRIEF.md
# Parallel Flash Programming-Mode Controller

This block stands in for the parallel programming port of an on-chip program memory. An external programmer sets an address, a data byte and a mode, then drives the high-voltage enable and an active-low program strobe. A byte write is self-timed. While it runs, reading the target address returns a polling pattern, and the ready flag reads low.

A chip erase takes a continuous low hold on the strobe. It returns every location to all ones and clears the lock bits and the write-error flag. Two lock bits hide the array contents from verify reads. A signature mode returns fixed identification bytes. The storage is a behavioural register array. Both the write time and the erase time are counted in clock cycles.

All inputs are synchronous to `clk_i`. A strobe event is a high-to-low change of `prog_n_i` between two consecutive clock edges. The mode encodings on `mode_i` are 0 verify, 1 write, 2 erase, 3 signature and 4 lock; every other value is unused.

Top module: `flash_prog_ctrl`

## Requirements
- R1: A strobe event while `mode_i`=1, `hv_en_i`=1 and `ready_o`=1, aimed at a blank (all-ones) location, starts a write. `ready_o` reads 0 from the clock edge that samples the event.
- R2: A write keeps `ready_o` low for exactly WR_CYCLES clock edges. It then stores the byte and raises `ready_o`, and a verify read returns the stored byte.
- R3: A strobe event in write mode with `hv_en_i`=0 starts nothing and leaves the array unchanged.
- R4: A write aimed at a location that is not blank is ignored and sets `err_o`. `err_o` stays set until a chip erase.
- R5: During a write, a verify read of the target address returns the complement of data bit 7 on bit 7 and zeros on bits 6:0. A verify read of any other address returns the stored contents.
- R6: Holding `prog_n_i` low with `mode_i`=2 and `hv_en_i`=1 for ER_CYCLES consecutive clock edges erases the chip. Every location then reads FFh, and `err_o` and both lock bits are cleared.
- R7: Releasing the strobe, or leaving erase mode, before ER_CYCLES edges have passed aborts the erase. The array, the lock bits and `err_o` are left unchanged.
- R8: In signature mode, address 030h reads 1Eh and 031h reads 51h. Address 032h reads FFh when HV_PROG=1 and 05h when HV_PROG=0. Every other address reads FFh.
- R9: A strobe event with `mode_i`=4 and `hv_en_i`=1 sets lock bit `addr_i[0]`. While either lock bit is set, verify reads return FFh. Signature reads are not affected.
- R10: After reset, `ready_o`=1, `err_o`=0, the locks are clear and every location reads FFh.
- R11: A strobe event during a running write is ignored. The target address and data of the running write are kept.
- R12: An unused `mode_i` value reads 00h on `rdata_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | 8 | Byte to program |
| mode_i | input | 3 | 0 verify, 1 write, 2 erase, 3 signature, 4 lock |
| hv_en_i | input | 1 | High-voltage programming enable |
| prog_n_i | input | 1 | Program strobe, active low |
| rdata_o | output | 8 | Read data (verify, polling, signature) |
| ready_o | output | 1 | 1 = ready, 0 = write in progress |
| err_o | output | 1 | Sticky non-blank write error |

## Verification
The bench builds the block with WR_CYCLES=6, ER_CYCLES=20 and MEM_AW=6, and keeps HV_PROG=1. With six write cycles, one write leaves room for a poll read of the target, a read of another address, a strobe landing inside the busy window and an edge-exact check of the ready flag. With twenty erase cycles, the bench can hold the strobe for one edge too few and then hold it long enough, and show that only the second hold clears the lock and error state.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;
  typedef logic [7:0] byte_t;

  typedef enum logic [2:0] {
    MODE_VERIFY = 3'd0,
    MODE_WRITE  = 3'd1,
    MODE_ERASE  = 3'd2,
    MODE_SIG    = 3'd3,
    MODE_LOCK   = 3'd4
  } prog_mode_e;

  localparam int    SIG_BASE   = 'h30;
  localparam byte_t SIG_MAKER  = 8'h1E;
  localparam byte_t SIG_PART   = 8'h51;
  localparam byte_t SIG_V_HIGH = 8'hFF;
  localparam byte_t SIG_V_LOW  = 8'h05;
endpackage

// File: rtl/flash_array.sv
module flash_array
  import flash_prog_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_idx_i,
  input  byte_t         wr_data_i,
  input  logic          erase_i,
  input  logic [AW-1:0] rd_idx_i,
  output byte_t         rd_data_o
);
  localparam int DEPTH = 1 << AW;

  byte_t mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (erase_i) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];

  // R6
  a_r6_erase_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |=> (mem_q[0] == 8'hFF) && (mem_q[DEPTH-1] == 8'hFF));

  // R2
  a_r2_commit_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !erase_i) |=> mem_q[$past(wr_idx_i)] == $past(wr_data_i));
endmodule

// File: rtl/flash_wr_seq.sv
module flash_wr_seq
  import flash_prog_pkg::*;
#(
  parameter int WR_CYCLES = 6,
  parameter int ADDR_W    = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              blank_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  byte_t             data_i,
  input  logic              erase_i,
  output logic              busy_o,
  output logic              commit_o,
  output logic [ADDR_W-1:0] tgt_addr_o,
  output byte_t             tgt_data_o,
  output logic              err_o
);
  localparam int CW = $clog2(WR_CYCLES + 1);

  logic              busy_q;
  logic [CW-1:0]     cnt_q;
  logic [ADDR_W-1:0] tgt_addr_q;
  byte_t             tgt_data_q;
  logic              err_q;

  assign commit_o = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      tgt_addr_q <= '0;
      tgt_data_q <= '0;
    end else if (!busy_q) begin
      if (req_i && blank_i) begin
        busy_q     <= 1'b1;
        cnt_q      <= CW'(WR_CYCLES - 1);
        tgt_addr_q <= addr_i;
        tgt_data_q <= data_i;
      end
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  // sticky: only an erase clears it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           err_q <= 1'b0;
    else if (erase_i)                      err_q <= 1'b0;
    else if (req_i && !busy_q && !blank_i) err_q <= 1'b1;
  end

  assign busy_o     = busy_q;
  assign tgt_addr_o = tgt_addr_q;
  assign tgt_data_o = tgt_data_q;
  assign err_o      = err_q;

  // R2
  a_r2_busy_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0) |=> busy_q && (cnt_q == $past(cnt_q) - CW'(1)));

  // R11
  a_r11_hold_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !commit_o) |=> $stable(tgt_addr_q) && $stable(tgt_data_q));

  // R4
  a_r4_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !erase_i) |=> err_q);
endmodule

// File: rtl/flash_erase_ctl.sv
module flash_erase_ctl #(
  parameter int ER_CYCLES = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  output logic erase_o
);
  localparam int CW = $clog2(ER_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign erase_o = hold_i && !done_q && (cnt_q == CW'(ER_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!hold_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (erase_o) done_q <= 1'b1;
      else         cnt_q  <= cnt_q + CW'(1);
    end
  end

  // R6
  a_r6_erase_needs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_o |-> $past(hold_i));

  // R7
  a_r7_release_aborts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_i |=> !erase_o);
endmodule

// File: rtl/flash_rd_path.sv
module flash_rd_path
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter bit HV_PROG = 1'b1
) (
  input  logic [2:0]        mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  byte_t             arr_data_i,
  input  logic              locked_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] tgt_addr_i,
  input  byte_t             tgt_data_i,
  output byte_t             rdata_o
);
  localparam byte_t SIG_VOLT = HV_PROG ? SIG_V_HIGH : SIG_V_LOW;

  logic poll_hit;
  assign poll_hit = busy_i && (addr_i == tgt_addr_i);

  always_comb begin
    rdata_o = '0;
    unique case (mode_i)
      MODE_VERIFY: begin
        if (poll_hit)      rdata_o = {~tgt_data_i[7], 7'b0};
        else if (locked_i) rdata_o = '1;
        else               rdata_o = arr_data_i;
      end
      MODE_SIG: begin
        if      (addr_i == ADDR_W'(SIG_BASE))     rdata_o = SIG_MAKER;
        else if (addr_i == ADDR_W'(SIG_BASE + 1)) rdata_o = SIG_PART;
        else if (addr_i == ADDR_W'(SIG_BASE + 2)) rdata_o = SIG_VOLT;
        else                                      rdata_o = '1;
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int MEM_AW    = 8,
  parameter int WR_CYCLES = 6,
  parameter int ER_CYCLES = 20,
  parameter bit HV_PROG   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic [2:0]        mode_i,
  input  logic              hv_en_i,
  input  logic              prog_n_i,
  output logic [7:0]        rdata_o,
  output logic              ready_o,
  output logic              err_o
);
  logic              prog_q;
  logic              strobe_fall;
  logic              wr_req, lock_req, erase_hold, erase_go;
  logic              busy, commit;
  logic [ADDR_W-1:0] tgt_addr;
  byte_t             tgt_data;
  byte_t             arr_data;
  logic [1:0]        lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prog_q <= 1'b1;
    else         prog_q <= prog_n_i;
  end

  assign strobe_fall = prog_q && !prog_n_i;
  assign wr_req      = strobe_fall && hv_en_i && (mode_i == MODE_WRITE);
  assign lock_req    = strobe_fall && hv_en_i && (mode_i == MODE_LOCK) && !busy;
  assign erase_hold  = !prog_n_i && hv_en_i && (mode_i == MODE_ERASE) && !busy;

  flash_array #(.AW(MEM_AW)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (commit),
    .wr_idx_i  (tgt_addr[MEM_AW-1:0]),
    .wr_data_i (tgt_data),
    .erase_i   (erase_go),
    .rd_idx_i  (addr_i[MEM_AW-1:0]),
    .rd_data_o (arr_data)
  );

  flash_wr_seq #(.WR_CYCLES(WR_CYCLES), .ADDR_W(ADDR_W)) u_wr_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (wr_req),
    .blank_i    (&arr_data),
    .addr_i     (addr_i),
    .data_i     (data_i),
    .erase_i    (erase_go),
    .busy_o     (busy),
    .commit_o   (commit),
    .tgt_addr_o (tgt_addr),
    .tgt_data_o (tgt_data),
    .err_o      (err_o)
  );

  flash_erase_ctl #(.ER_CYCLES(ER_CYCLES)) u_erase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hold_i  (erase_hold),
    .erase_o (erase_go)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lock_q <= '0;
    else if (erase_go) lock_q <= '0;
    else if (lock_req) lock_q[addr_i[0]] <= 1'b1;
  end

  flash_rd_path #(.ADDR_W(ADDR_W), .HV_PROG(HV_PROG)) u_rd (
    .mode_i     (mode_i),
    .addr_i     (addr_i),
    .arr_data_i (arr_data),
    .locked_i   (|lock_q),
    .busy_i     (busy),
    .tgt_addr_i (tgt_addr),
    .tgt_data_i (tgt_data),
    .rdata_o    (rdata_o)
  );

  assign ready_o = !busy;

  // R1
  a_r1_ready_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(mode_i == MODE_WRITE) && $past(hv_en_i) && $past(!prog_n_i));

  // R3
  a_r3_no_start_without_hv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hv_en_i && ready_o) |=> ready_o);

  // R5
  a_r5_poll_low_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_VERIFY && busy && addr_i == tgt_addr) |-> rdata_o[6:0] == 7'b0);

  // R9
  a_r9_lock_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_VERIFY && lock_q != '0 && !(busy && addr_i == tgt_addr))
      |-> rdata_o == 8'hFF);
endmodule

// File: tb/flash_prog_ctrl_bench.sv
`timescale 1ns/100ps
module flash_prog_ctrl_bench;
  localparam int ADDR_W = 12;
  localparam int WR_CYC = 6;
  localparam int ER_CYC = 20;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [7:0]        data_i = '0;
  logic [2:0]        mode_i = 3'd0;
  logic              hv_en_i = 1'b0;
  logic              prog_n_i = 1'b1;
  logic [7:0]        rdata_o;
  logic              ready_o;
  logic              err_o;

  always #2.5 clk = ~clk;

  flash_prog_ctrl #(
    .ADDR_W(ADDR_W), .MEM_AW(6), .WR_CYCLES(WR_CYC), .ER_CYCLES(ER_CYC), .HV_PROG(1'b1)
  ) u_flash_prog_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .data_i(data_i), .mode_i(mode_i),
    .hv_en_i(hv_en_i), .prog_n_i(prog_n_i), .rdata_o(rdata_o), .ready_o(ready_o), .err_o(err_o)
  );

  typedef struct {
    int         kind;   // 0 rdata, 1 ready, 2 err
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic expect_now(int kind, logic [7:0] v, string tag);
    item_t it;
    it.kind = kind; it.exp = v; it.tag = tag;
    q.push_back(it);
  endtask

  always begin
    @(negedge clk);
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.kind)
        0:       act = rdata_o;
        1:       act = {7'b0, ready_o};
        default: act = {7'b0, err_o};
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic rd(logic [2:0] m, int a, logic [7:0] e, string tag);
    @(negedge clk);
    mode_i = m; addr_i = ADDR_W'(a); prog_n_i = 1'b1; hv_en_i = 1'b0;
    expect_now(0, e, tag);
  endtask

  task automatic write_byte(int a, logic [7:0] d, logic hv);
    @(negedge clk);
    mode_i = 3'd1; addr_i = ADDR_W'(a); data_i = d; hv_en_i = hv; prog_n_i = 1'b0;
    @(negedge clk);
    prog_n_i = 1'b1;
  endtask

  task automatic erase_hold(int k);
    @(negedge clk);
    mode_i = 3'd2; hv_en_i = 1'b1; prog_n_i = 1'b0;
    repeat (k) @(negedge clk);
    prog_n_i = 1'b1; mode_i = 3'd0; hv_en_i = 1'b0;
  endtask

  task automatic lock_set(int sel);
    @(negedge clk);
    mode_i = 3'd4; addr_i = ADDR_W'(sel); hv_en_i = 1'b1; prog_n_i = 1'b0;
    @(negedge clk);
    prog_n_i = 1'b1; mode_i = 3'd0; hv_en_i = 1'b0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R10 reset state
    @(negedge clk);
    expect_now(1, 8'h01, "R10 ready");
    expect_now(2, 8'h00, "R10 err");
    rd(3'd0, 5, 8'hFF, "R10 blank");

    // R1/R2/R5 timed write of 5Ah to address 5
    write_byte(5, 8'h5A, 1'b1);
    mode_i = 3'd0; hv_en_i = 1'b0;
    expect_now(1, 8'h00, "R1 busy");
    expect_now(0, 8'h80, "R5 poll");
    for (int i = 1; i < WR_CYC; i++) begin
      @(negedge clk);
      addr_i = (i == 2) ? ADDR_W'(6) : ADDR_W'(5);
      expect_now(1, 8'h00, "R2 busy window");
      expect_now(0, (i == 2) ? 8'hFF : 8'h80, "R5 poll/other");
    end
    @(negedge clk);
    expect_now(1, 8'h01, "R2 ready back");
    rd(3'd0, 5, 8'h5A, "R2 stored");

    // R11 strobe during busy ignored
    write_byte(7, 8'hC3, 1'b1);
    mode_i = 3'd0; addr_i = ADDR_W'(7);
    expect_now(0, 8'h00, "R5 poll C3");
    @(negedge clk);
    mode_i = 3'd1; addr_i = ADDR_W'(8); data_i = 8'h11; hv_en_i = 1'b1; prog_n_i = 1'b0;
    @(negedge clk);
    prog_n_i = 1'b1;
    repeat (6) @(negedge clk);
    expect_now(1, 8'h01, "R11 ready");
    rd(3'd0, 7, 8'hC3, "R11 kept");
    rd(3'd0, 8, 8'hFF, "R11 ignored");

    // R3 no hv
    write_byte(9, 8'h22, 1'b0);
    expect_now(1, 8'h01, "R3 ready");
    rd(3'd0, 9, 8'hFF, "R3 untouched");

    // R4 non-blank write
    write_byte(5, 8'h12, 1'b1);
    expect_now(1, 8'h01, "R4 ready");
    expect_now(2, 8'h01, "R4 err");
    rd(3'd0, 5, 8'h5A, "R4 kept");
    @(negedge clk);
    expect_now(2, 8'h01, "R4 sticky");

    // R8 signature, R12 unused mode
    rd(3'd3, 'h30, 8'h1E, "R8 sig0");
    rd(3'd3, 'h31, 8'h51, "R8 sig1");
    rd(3'd3, 'h32, 8'hFF, "R8 sig2");
    rd(3'd3, 'h33, 8'hFF, "R8 other");
    rd(3'd5, 5, 8'h00, "R12 unused");

    // R9 lock
    lock_set(0);
    rd(3'd0, 5, 8'hFF, "R9 masked");
    rd(3'd3, 'h31, 8'h51, "R9 sig");

    // R7 aborted erase
    erase_hold(ER_CYC - 1);
    @(negedge clk);
    expect_now(2, 8'h01, "R7 err kept");
    rd(3'd0, 5, 8'hFF, "R7 still locked");

    // R6 full erase
    erase_hold(ER_CYC + 2);
    @(negedge clk);
    expect_now(2, 8'h00, "R6 err clear");
    rd(3'd0, 5, 8'hFF, "R6 blank 5");
    rd(3'd0, 7, 8'hFF, "R6 blank 7");
    write_byte(5, 8'h33, 1'b1);
    repeat (WR_CYC + 1) @(negedge clk);
    rd(3'd0, 5, 8'h33, "R6 lock cleared");

    repeat (2) @(negedge clk);
    finished = 1'b1;
    summary();
  end
endmodule